// File: doc/BRIEF.md
# Frame Buffer Fetch Address Sequencer

This block produces the stream of read addresses a display controller uses to pull pixel data out of external memory. Software programs a base address for each panel half. The base register is a shadow. A separate live pointer walks the frame sixteen bytes at a time, one step per accepted fetch. At each frame boundary, and when the display is switched on, the live pointer is loaded again from the shadow. Software can therefore stage the next frame buffer address at any time and have it take effect cleanly at the following frame.

Every reload of a live pointer sets a per-channel update flag. Together with an enable bit, these flags drive the interrupt line. The interrupt tells software that the shadow has been consumed and that a new address may be written. In single-panel mode only the upper channel runs and it covers the whole frame. In dual-panel mode both channels run with alternating fetches, and each covers half the programmed frame length.

The sequencer is a three-state machine:
- OFF: display disabled, no requests.
- UPPER: requesting for the upper channel.
- LOWER: requesting for the lower channel.

Its transitions are:
- OFF→UPPER when the display enable is seen high. Both active pointers are loaded on this transition.
- UPPER→LOWER on an accepted fetch in dual mode.
- UPPER→UPPER on an accepted fetch in single mode.
- LOWER→UPPER on an accepted fetch.
- Any state→OFF when the display enable is low.

Top module: `fbuf_addr_ptr`

## Requirements
- R1: Register address 0 holds the upper base and address 1 holds the lower base. A write stores the data with bits 3:0 forced to zero, and a read returns the stored value.
- R2: When the display enable is seen high while the sequencer is OFF, each active live pointer is loaded from its base. The first fetch address of a channel is then its base, even if an earlier run stopped mid-frame.
- R3: A fetch is accepted when fetch_req and fetch_ack are both high at a clock edge. Each accepted fetch advances that channel's pointer by 16. While a request waits for acknowledge, its address and channel stay unchanged.
- R4: After a channel has accepted its per-channel frame length of fetches, its pointer reloads from the base value held at that moment. A base written mid-frame is therefore first used at the next frame.
- R5: Every pointer reload, whether from enable or from end of frame, sets that channel's update flag. The flags are read at address 3, with bit 0 for upper and bit 1 for lower. Writing 1 to a flag bit clears it.
- R6: irq equals control bit 1 (interrupt enable) ANDed with the OR of the update flags.
- R7: While the display enable is low, fetch_req stays low whatever fetch_ack does.
- R8: Control bit 0 at address 2 selects dual-panel mode. A write to this bit is ignored while the display is enabled.
- R9: In dual mode, fetches alternate upper then lower. fetch_ch is 0 for upper and 1 for lower, and each channel's frame length is frame_len/2. In single mode fetch_ch is 0 and the frame length is frame_len.
- R10: After reset, fetch_req and irq are low, and the control and status registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | AW | Register write data |
| reg_rdata | output | AW | Register read data (combinational) |
| disp_en | input | 1 | Display enable |
| frame_len | input | LEN_W | Frame length in 16-byte units |
| fetch_req | output | 1 | Fetch request |
| fetch_ack | input | 1 | Fetch accepted by memory side |
| fetch_addr | output | AW | Fetch address |
| fetch_ch | output | 1 | Channel of the current request |
| irq | output | 1 | Interrupt request |

## Verification
The bench moves the base address halfway through a running frame. A design that reloaded immediately, instead of at the boundary, would jump too early and break the expected address stream.

It also stops a run mid-frame and re-enables. A pointer that only held its value would then resume at the old position instead of at the base.

Dual mode is run with full frames and with a one-quadword half frame. These cases expose wrong channel interleaving, a frame length that is not halved, and an off-by-one in the wrap count.

A mode write while enabled, the interrupt masking, and write-one-to-clear of the flags are each read back at the ports.

// File: rtl/fbp_pkg.sv
package fbp_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_UPPER = 2'd1,
        ST_LOWER = 2'd2
    } fbp_state_e;

    localparam logic [1:0] RA_BASE_UP = 2'd0;
    localparam logic [1:0] RA_BASE_LO = 2'd1;
    localparam logic [1:0] RA_CTRL    = 2'd2;
    localparam logic [1:0] RA_STAT    = 2'd3;

    localparam int QW_BYTES = 16;
    localparam int NUM_CH   = 2;
endpackage

// File: rtl/fbp_regs.sv
module fbp_regs
    import fbp_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [AW-1:0]     reg_wdata,
    output logic [AW-1:0]     reg_rdata,
    input  logic              disp_en,
    input  logic [NUM_CH-1:0] reload,
    output logic [AW-1:0]     base_up,
    output logic [AW-1:0]     base_lo,
    output logic              dual_mode,
    output logic              irq_en,
    output logic              irq
);
    localparam int ALIGN = $clog2(QW_BYTES);

    logic [NUM_CH-1:0] flags_q;
    logic [NUM_CH-1:0] clr;

    // Shadow base registers: no reset, contents undefined until written
    always_ff @(posedge clk) begin
        if (reg_we && reg_addr == RA_BASE_UP)
            base_up <= {reg_wdata[AW-1:ALIGN], {ALIGN{1'b0}}};
        if (reg_we && reg_addr == RA_BASE_LO)
            base_lo <= {reg_wdata[AW-1:ALIGN], {ALIGN{1'b0}}};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dual_mode <= 1'b0;
            irq_en    <= 1'b0;
        end else if (reg_we && reg_addr == RA_CTRL) begin
            if (!disp_en)
                dual_mode <= reg_wdata[0];
            irq_en <= reg_wdata[1];
        end
    end

    assign clr = (reg_we && reg_addr == RA_STAT) ? reg_wdata[NUM_CH-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flags_q <= '0;
        else
            flags_q <= (flags_q & ~clr) | reload;
    end

    assign irq = irq_en & (|flags_q);

    always_comb begin
        unique case (reg_addr)
            RA_BASE_UP: reg_rdata = base_up;
            RA_BASE_LO: reg_rdata = base_lo;
            RA_CTRL:    reg_rdata = {{(AW-2){1'b0}}, irq_en, dual_mode};
            default:    reg_rdata = {{(AW-NUM_CH){1'b0}}, flags_q};
        endcase
    end
endmodule

// File: rtl/fbp_chan.sv
module fbp_chan
    import fbp_pkg::*;
#(
    parameter int AW    = 32,
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [AW-1:0]    base,
    input  logic [LEN_W-1:0] len,
    output logic [AW-1:0]    cur_addr,
    output logic             wrap
);
    logic [LEN_W-1:0] cnt_q;

    assign wrap = step && (cnt_q == len - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr <= '0;
            cnt_q    <= '0;
        end else if (load || wrap) begin
            cur_addr <= base;
            cnt_q    <= '0;
        end else if (step) begin
            cur_addr <= cur_addr + AW'(QW_BYTES);
            cnt_q    <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/fbp_fsm.sv
module fbp_fsm
    import fbp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic disp_en,
    input  logic fetch_ack,
    input  logic dual_mode,
    output logic fetch_req,
    output logic sel_lower,
    output logic load_all,
    output logic step_up,
    output logic step_lo
);
    fbp_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (!disp_en) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:   state_d = ST_UPPER;
                ST_UPPER: if (fetch_ack) state_d = dual_mode ? ST_LOWER : ST_UPPER;
                ST_LOWER: if (fetch_ack) state_d = ST_UPPER;
                default:  state_d = ST_OFF;
            endcase
        end
    end

    always_comb begin
        fetch_req = 1'b0;
        sel_lower = 1'b0;
        load_all  = 1'b0;
        unique case (state_q)
            ST_OFF:   load_all  = disp_en;
            ST_UPPER: fetch_req = disp_en;
            ST_LOWER: begin
                fetch_req = disp_en;
                sel_lower = 1'b1;
            end
            default: ;
        endcase
        step_up = fetch_req && fetch_ack && !sel_lower;
        step_lo = fetch_req && fetch_ack && sel_lower;
    end
endmodule

// File: rtl/fbuf_addr_ptr.sv
module fbuf_addr_ptr
    import fbp_pkg::*;
#(
    parameter int AW    = 32,
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [1:0]       reg_addr,
    input  logic [AW-1:0]    reg_wdata,
    output logic [AW-1:0]    reg_rdata,
    input  logic             disp_en,
    input  logic [LEN_W-1:0] frame_len,
    output logic             fetch_req,
    input  logic             fetch_ack,
    output logic [AW-1:0]    fetch_addr,
    output logic             fetch_ch,
    output logic             irq
);
    logic [AW-1:0]     base_up, base_lo;
    logic              dual_mode, irq_en;
    logic              sel_lower, load_all, step_up, step_lo;
    logic [NUM_CH-1:0] ch_load, ch_step, ch_wrap;
    logic [AW-1:0]     ch_base [NUM_CH];
    logic [AW-1:0]     ch_cur  [NUM_CH];
    logic [LEN_W-1:0]  len_ch;

    fbp_regs #(.AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .disp_en(disp_en),
        .reload(ch_load | ch_wrap), .base_up(base_up), .base_lo(base_lo),
        .dual_mode(dual_mode), .irq_en(irq_en), .irq(irq)
    );

    fbp_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .disp_en(disp_en), .fetch_ack(fetch_ack),
        .dual_mode(dual_mode), .fetch_req(fetch_req), .sel_lower(sel_lower),
        .load_all(load_all), .step_up(step_up), .step_lo(step_lo)
    );

    assign len_ch     = dual_mode ? (frame_len >> 1) : frame_len;
    assign ch_base[0] = base_up;
    assign ch_base[1] = base_lo;
    assign ch_load    = {load_all & dual_mode, load_all};
    assign ch_step    = {step_lo, step_up};

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        fbp_chan #(.AW(AW), .LEN_W(LEN_W)) u_chan (
            .clk(clk), .rst_n(rst_n), .load(ch_load[g]), .step(ch_step[g]),
            .base(ch_base[g]), .len(len_ch), .cur_addr(ch_cur[g]),
            .wrap(ch_wrap[g])
        );
    end

    assign fetch_ch   = sel_lower;
    assign fetch_addr = sel_lower ? ch_cur[1] : ch_cur[0];
endmodule

// File: rtl/fbuf_addr_ptr_chk.sv
module fbuf_addr_ptr_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_we,
    input logic [1:0]    reg_addr,
    input logic          disp_en,
    input logic          fetch_req,
    input logic          fetch_ack,
    input logic [AW-1:0] fetch_addr,
    input logic          fetch_ch,
    input logic          irq,
    input logic          irq_en,
    input logic          dual_mode,
    input logic [AW-1:0] base_up
);
    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |-> fetch_addr[3:0] == 4'd0);                          // R1

    AST_NO_REQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_en |-> !fetch_req);                                          // R7

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !fetch_ack) |=> (!fetch_req || ($stable(fetch_addr) && $stable(fetch_ch)))); // R3

    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && fetch_ack && !dual_mode) |=>
            (!fetch_req || fetch_addr == $past(fetch_addr) + AW'(16) || fetch_addr == $past(base_up))); // R4

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);                                                 // R6

    AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        disp_en |=> $stable(dual_mode));                                   // R8

    AST_SINGLE_CH: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !dual_mode) |-> !fetch_ch);                          // R9

    AST_DUAL_ALT: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && fetch_ack && dual_mode && disp_en) |=> (!fetch_req || fetch_ch != $past(fetch_ch))); // R9

    wire unused_ok = &{1'b0, reg_we, reg_addr};
endmodule

bind fbuf_addr_ptr fbuf_addr_ptr_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .disp_en(disp_en), .fetch_req(fetch_req), .fetch_ack(fetch_ack),
    .fetch_addr(fetch_addr), .fetch_ch(fetch_ch), .irq(irq),
    .irq_en(irq_en), .dual_mode(dual_mode), .base_up(base_up)
);

// File: tb/fbuf_addr_ptr_bench.sv
`timescale 1ns/1ps
module fbuf_addr_ptr_bench;
    localparam int AW = 32;
    localparam int LEN_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reg_we = 1'b0;
    logic [1:0]       reg_addr = 2'd0;
    logic [AW-1:0]    reg_wdata = '0;
    logic [AW-1:0]    reg_rdata;
    logic             disp_en = 1'b0;
    logic [LEN_W-1:0] frame_len = 16'd4;
    logic             fetch_req;
    logic             fetch_ack = 1'b0;
    logic [AW-1:0]    fetch_addr;
    logic             fetch_ch;
    logic             irq;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    logic [AW:0] exp_q[$];

    always #5 clk = ~clk;

    fbuf_addr_ptr #(.AW(AW), .LEN_W(LEN_W)) u_fbuf_addr_ptr (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .disp_en(disp_en),
        .frame_len(frame_len), .fetch_req(fetch_req), .fetch_ack(fetch_ack),
        .fetch_addr(fetch_addr), .fetch_ch(fetch_ch), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input logic [AW:0] act, input logic [AW:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push(input logic ch, input logic [AW-1:0] a);
        exp_q.push_back({ch, a});
    endtask

    task automatic wr(input logic [1:0] a, input logic [AW-1:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [AW-1:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic drain();
        fetch_ack = 1'b1;
        disp_en = 1'b1;
        wait (exp_q.size() == 0);
        fetch_ack = 1'b0;
    endtask

    task automatic stop();
        @(negedge clk);
        disp_en = 1'b0;
        @(negedge clk);
    endtask

    // Monitor: compare accepted fetches against the scoreboard
    always @(negedge clk) begin
        if (rst_n && fetch_req && fetch_ack) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3 unexpected fetch", {fetch_ch, fetch_addr}, '0);
            end else begin
                logic [AW:0] e;
                e = exp_q.pop_front();
                chk({fetch_ch, fetch_addr} == e, "R2/R3/R4/R9 fetch stream", {fetch_ch, fetch_addr}, e);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            chk(1'b0, "watchdog", '0, '1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        chk(fetch_req == 1'b0, "R10 req", {32'b0, fetch_req}, '0);
        chk(irq == 1'b0, "R10 irq", {32'b0, irq}, '0);
        rd(2'd2, v); chk(v == 0, "R10 ctrl", {1'b0, v}, '0);
        rd(2'd3, v); chk(v == 0, "R10 status", {1'b0, v}, '0);

        // R1 alignment masking and readback
        @(negedge clk);
        wr(2'd0, 32'h1234_567F);
        rd(2'd0, v); chk(v == 32'h1234_5670, "R1 upper base", {1'b0, v}, {1'b0, 32'h1234_5670});
        wr(2'd1, 32'hABCD_EF0A);
        rd(2'd1, v); chk(v == 32'hABCD_EF00, "R1 lower base", {1'b0, v}, {1'b0, 32'hABCD_EF00});

        // R7 no request while disabled
        fetch_ack = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(fetch_req == 1'b0, "R7 idle request", {32'b0, fetch_req}, '0);
        end
        fetch_ack = 1'b0;

        // R4 single mode, base changed mid-frame takes effect next frame
        frame_len = 16'd4;
        wr(2'd0, 32'h1000_0000);
        for (int i = 0; i < 4; i++) push(1'b0, 32'h1000_0000 + 32'(16 * i));
        for (int i = 0; i < 4; i++) push(1'b0, 32'h2000_0000 + 32'(16 * i));
        push(1'b0, 32'h2000_0000);
        fetch_ack = 1'b1;
        disp_en = 1'b1;
        wait (exp_q.size() == 7);
        wr(2'd0, 32'h2000_0000);
        drain();
        stop();

        // R5 flag set by reloads, R6 masked irq, write-one clears
        rd(2'd3, v); chk(v == 32'd1, "R5 upper flag set", {1'b0, v}, 33'd1);
        chk(irq == 1'b0, "R6 irq masked", {32'b0, irq}, '0);
        wr(2'd2, 32'd2);
        chk(irq == 1'b1, "R6 irq enabled", {32'b0, irq}, 33'd1);
        wr(2'd3, 32'd1);
        rd(2'd3, v); chk(v == 32'd0, "R5 flag cleared", {1'b0, v}, '0);
        chk(irq == 1'b0, "R6 irq after clear", {32'b0, irq}, '0);

        // R2 partial frame then re-enable restarts from base
        wr(2'd0, 32'h3000_0040);
        push(1'b0, 32'h3000_0040); push(1'b0, 32'h3000_0050);
        drain(); stop();
        push(1'b0, 32'h3000_0040); push(1'b0, 32'h3000_0050);
        drain(); stop();

        // R3 request holds without acknowledge
        disp_en = 1'b1;
        repeat (3) @(negedge clk);
        chk(fetch_req && fetch_addr == 32'h3000_0040, "R3 held request", {fetch_ch, fetch_addr}, {1'b0, 32'h3000_0040});
        stop();

        // R4 single mode length one: every fetch reloads
        frame_len = 16'd1;
        push(1'b0, 32'h3000_0040); push(1'b0, 32'h3000_0040); push(1'b0, 32'h3000_0040);
        drain(); stop();

        // R8/R9 dual mode, alternating channels, halved frame
        wr(2'd3, 32'd3);
        wr(2'd2, 32'd1);
        wr(2'd0, 32'h4000_0000);
        wr(2'd1, 32'h5000_0000);
        frame_len = 16'd4;
        push(1'b0, 32'h4000_0000); push(1'b1, 32'h5000_0000);
        push(1'b0, 32'h4000_0010); push(1'b1, 32'h5000_0010);
        push(1'b0, 32'h4000_0000); push(1'b1, 32'h5000_0000);
        drain();
        @(negedge clk);
        wr(2'd2, 32'd0);
        rd(2'd2, v); chk(v[0] == 1'b1, "R8 mode write ignored while enabled", {1'b0, v}, 33'd1);
        stop();
        rd(2'd3, v); chk(v == 32'd3, "R5 both flags set", {1'b0, v}, 33'd3);

        // R9 dual with half frame of one quadword
        wr(2'd2, 32'd1);
        frame_len = 16'd2;
        push(1'b0, 32'h4000_0000); push(1'b1, 32'h5000_0000);
        push(1'b0, 32'h4000_0000); push(1'b1, 32'h5000_0000);
        drain(); stop();

        // R8 mode write accepted while disabled
        wr(2'd2, 32'd0);
        rd(2'd2, v); chk(v[0] == 1'b0, "R8 mode write while disabled", {1'b0, v}, '0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule